// File: doc/BRIEF.md
# DRAM Read/Write Turnaround Scheduler

This block is the controlling state machine inside a DRAM command multiplexer. It decides whether the command bus currently serves reads, writes or a refresh. When it changes direction, it inserts a bus turnaround wait whose length comes from the PHY latencies. It tells two upstream choosers which command kinds they may pick: a command chooser for activates and precharges, and a request chooser for column reads and writes. It also tells the PHY steering logic which chooser drives each DFI phase slot.

Two spacing timers limit how often commands may issue. One keeps activates at least `T_RRD` cycles apart and the other keeps column commands at least `T_CCD` cycles apart. A per-direction residency counter stops either direction from starving the other. A refresh from the refresher waits in a dedicated state until every bank machine has granted it. Only then is the refresh placed on phase 0.

Top module: `dram_turnaround_sched`

## Requirements
- R1: After reset the scheduler is in read mode, which is `mode` = 0. In this mode `want_cmds`, `want_acts` and `want_reads` are 1, and `want_writes` and `refresh_req` are 0.
- R2: When read mode sees `write_avail` and leaves, `mode` is 1 (read-to-write wait) for `READ_LATENCY`-1 cycles. It then becomes 2 (write), exactly `READ_LATENCY` cycles after the deciding edge.
- R3: Leaving write mode passes through `mode` = 3 (write-to-read wait). Read mode is reached `T_WTR + ceil(CWL/NPHASES) + T_CCD` cycles after the deciding edge.
- R4: While the other direction is pending, read mode stays for exactly `READ_TIME` cycles and write mode for exactly `WRITE_TIME` cycles, counted from entry. The read residency counter is already expired after reset, so with both directions pending the first read mode leaves at the first edge.
- R5: Read mode with no write pending stays in read mode. Write mode with no read pending stays in write mode.
- R6: In read mode the enables `want_cmds`, `want_acts` and `want_reads` are high. In write mode `want_writes` replaces `want_reads`. Reads and writes are never enabled together, and all enables are low in the wait and refresh modes.
- R7: An `act_fire` pulse drops `want_acts` for `T_RRD`-1 cycles, so two activates are at least `T_RRD` cycles apart. A value of 0 or 1 means no restriction.
- R8: A `cas_fire` pulse drops `want_reads` and `want_writes` for `T_CCD`-1 cycles.
- R9: Each phase slot in `steer_sel[2p+1:2p]` is coded 0 = idle, 1 = command chooser, 2 = request chooser, 3 = refresh. In read mode phase `RD_PH` carries code 2 when `req_valid` is high, and phase `RD_CMD_PH` carries code 1 when `cmd_valid` is high. Write mode does the same with `WR_PH` and `WR_CMD_PH`. All other slots are 0.
- R10: When the data phase and the command phase are the same slot, as in a single-phase setup, a valid command-chooser entry takes the slot. The read or write enable is then withheld, so the activate issues before the column command.
- R11: A `refresh_valid` seen in read mode moves to `mode` = 4 with `refresh_req` high. `refresh_ack` and the phase-0 refresh code 3 appear only when every bit of `refresh_gnt` is high. The next cycle returns to read mode.
- R12: A `refresh_valid` seen in write mode first goes through the write-to-read wait. It then enters refresh from read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| read_avail | input | 1 | Some bank machine has a read pending |
| write_avail | input | 1 | Some bank machine has a write pending |
| cmd_valid | input | 1 | Command chooser holds a valid entry |
| req_valid | input | 1 | Request chooser holds a valid entry |
| act_fire | input | 1 | An activate issued this cycle |
| cas_fire | input | 1 | A read or write issued this cycle |
| refresh_valid | input | 1 | Refresher requests a refresh |
| refresh_gnt | input | NBANKS | Per-bank refresh permission |
| want_cmds | output | 1 | Command chooser may pick non-activate commands |
| want_acts | output | 1 | Command chooser may pick activates |
| want_reads | output | 1 | Request chooser may pick reads |
| want_writes | output | 1 | Request chooser may pick writes |
| steer_sel | output | 2*NPHASES | Per-phase source select |
| refresh_req | output | 1 | Asks all bank machines to close for refresh |
| refresh_ack | output | 1 | Refresh command accepted this cycle |
| mode | output | 3 | 0 read, 1 read-to-write, 2 write, 3 write-to-read, 4 refresh |

## Verification
The hardest behaviour to reach from the ports is anti-starvation expiry. It only shows when both directions stay pending for the full residency window, and it needs a mode entered through a turnaround, so the counter is freshly loaded. The bench holds both availability inputs high right after a write-to-read wait completes. It counts the read-mode cycles, then the write-mode cycles that follow. Refresh gathering is the other hard case: grants are raised one bank at a time, and the acknowledge is checked to stay low until the last one arrives.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [2:0] {
        ST_READ    = 3'd0,
        ST_RTW     = 3'd1,
        ST_WRITE   = 3'd2,
        ST_WTR     = 3'd3,
        ST_REFRESH = 3'd4
    } sched_state_e;

    localparam logic [1:0] SLOT_IDLE = 2'd0;
    localparam logic [1:0] SLOT_CMD  = 2'd1;
    localparam logic [1:0] SLOT_REQ  = 2'd2;
    localparam logic [1:0] SLOT_REF  = 2'd3;

endpackage

// File: rtl/spacing_timer.sv
module spacing_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic ok
);
    localparam int CW   = $clog2(LIMIT + 2);
    localparam int LOAD = (LIMIT > 1) ? LIMIT - 1 : 0;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (fire) begin
            cnt_d = CW'(LOAD);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ok = (cnt_q == '0);

    generate
        if (LIMIT > 1) begin : g_gap_chk
            assert_gap_R7_R8: assert property (@(posedge clk) disable iff (!rst_n)
                fire |=> !ok);
        end
    endgenerate

endmodule

// File: rtl/sched_fsm.sv
module sched_fsm
    import sched_pkg::*;
#(
    parameter int READ_LATENCY = 5,
    parameter int WTR_LATENCY  = 5,
    parameter int READ_TIME    = 32,
    parameter int WRITE_TIME   = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         read_avail,
    input  logic         write_avail,
    input  logic         refresh_valid,
    input  logic         all_granted,
    output sched_state_e state,
    output logic         ref_fire
);
    localparam int RTW_WAIT = (READ_LATENCY >= 2) ? READ_LATENCY - 2 : 0;
    localparam int WTR_WAIT = (WTR_LATENCY >= 2) ? WTR_LATENCY - 2 : 0;
    localparam int MAXW     = (RTW_WAIT > WTR_WAIT) ? RTW_WAIT : WTR_WAIT;
    localparam int WW       = $clog2(MAXW + 2);
    localparam int MAXD     = (READ_TIME > WRITE_TIME) ? READ_TIME : WRITE_TIME;
    localparam int DW       = $clog2(MAXD + 2);

    typedef struct packed {
        sched_state_e    st;
        logic [WW-1:0]   wait_cnt;
        logic [DW-1:0]   dir_cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if ((fsm_q.st == ST_READ || fsm_q.st == ST_WRITE) && fsm_q.dir_cnt != '0) begin
            fsm_d.dir_cnt = fsm_q.dir_cnt - DW'(1);
        end
        unique case (fsm_q.st)
            ST_READ: begin
                if (refresh_valid) begin
                    fsm_d.st = ST_REFRESH;
                end else if (write_avail && (!read_avail || fsm_q.dir_cnt == '0)) begin
                    fsm_d.st       = ST_RTW;
                    fsm_d.wait_cnt = WW'(RTW_WAIT);
                end
            end
            ST_RTW: begin
                if (fsm_q.wait_cnt == '0) begin
                    fsm_d.st      = ST_WRITE;
                    fsm_d.dir_cnt = DW'(WRITE_TIME - 1);
                end else begin
                    fsm_d.wait_cnt = fsm_q.wait_cnt - WW'(1);
                end
            end
            ST_WRITE: begin
                if (refresh_valid ||
                    (read_avail && (!write_avail || fsm_q.dir_cnt == '0))) begin
                    fsm_d.st       = ST_WTR;
                    fsm_d.wait_cnt = WW'(WTR_WAIT);
                end
            end
            ST_WTR: begin
                if (fsm_q.wait_cnt == '0) begin
                    fsm_d.st      = ST_READ;
                    fsm_d.dir_cnt = DW'(READ_TIME - 1);
                end else begin
                    fsm_d.wait_cnt = fsm_q.wait_cnt - WW'(1);
                end
            end
            ST_REFRESH: begin
                if (!refresh_valid || all_granted) begin
                    fsm_d.st      = ST_READ;
                    fsm_d.dir_cnt = DW'(READ_TIME - 1);
                end
            end
            default: fsm_d.st = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.st       <= ST_READ;
            fsm_q.wait_cnt <= '0;
            fsm_q.dir_cnt  <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state    = fsm_q.st;
    assign ref_fire = (fsm_q.st == ST_REFRESH) && refresh_valid && all_granted;

    assert_rtw_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_WRITE && $past(fsm_q.st) != ST_WRITE) |-> $past(fsm_q.st) == ST_RTW);

    assert_wtr_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_WRITE && !refresh_valid && read_avail && !write_avail)
        |=> fsm_q.st == ST_WTR);

    assert_starve_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_WRITE && fsm_q.dir_cnt == '0 && read_avail) |=> fsm_q.st != ST_WRITE);

    assert_read_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_READ && !write_avail && !refresh_valid) |=> fsm_q.st == ST_READ);

    assert_ref_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_REFRESH && refresh_valid && !all_granted) |=> fsm_q.st == ST_REFRESH);

endmodule

// File: rtl/phase_steer.sv
module phase_steer
    import sched_pkg::*;
#(
    parameter int NPHASES   = 2,
    parameter int RD_PH     = 0,
    parameter int RD_CMD_PH = 1,
    parameter int WR_PH     = 1,
    parameter int WR_CMD_PH = 0
) (
    input  sched_state_e           state,
    input  logic                   cmd_valid,
    input  logic                   req_valid,
    input  logic                   ref_fire,
    output logic [2*NPHASES-1:0]   sel
);
    function automatic logic [1:0] pick(input bit is_data, input bit is_cmd,
                                        input logic cv, input logic rv);
        logic [1:0] s;
        s = SLOT_IDLE;
        if (is_cmd && cv)       s = SLOT_CMD;
        else if (is_data && rv) s = SLOT_REQ;
        return s;
    endfunction

    generate
        for (genvar p = 0; p < NPHASES; p++) begin : g_phase
            localparam bit RD_D = (p == RD_PH);
            localparam bit RD_C = (p == RD_CMD_PH);
            localparam bit WR_D = (p == WR_PH);
            localparam bit WR_C = (p == WR_CMD_PH);
            localparam bit REF0 = (p == 0);
            logic [1:0] slot_d;
            always_comb begin
                slot_d = SLOT_IDLE;
                unique case (state)
                    ST_READ:    slot_d = pick(RD_D, RD_C, cmd_valid, req_valid);
                    ST_WRITE:   slot_d = pick(WR_D, WR_C, cmd_valid, req_valid);
                    ST_REFRESH: slot_d = (REF0 && ref_fire) ? SLOT_REF : SLOT_IDLE;
                    default:    slot_d = SLOT_IDLE;
                endcase
            end
            assign sel[2*p +: 2] = slot_d;
        end
    endgenerate

endmodule

// File: rtl/dram_turnaround_sched.sv
module dram_turnaround_sched
    import sched_pkg::*;
#(
    parameter int NPHASES      = 2,
    parameter int RD_PH        = 0,
    parameter int RD_CMD_PH    = 1,
    parameter int WR_PH        = 1,
    parameter int WR_CMD_PH    = 0,
    parameter int READ_LATENCY = 5,
    parameter int CWL          = 3,
    parameter int T_WTR        = 2,
    parameter int T_CCD        = 1,
    parameter int T_RRD        = 0,
    parameter int READ_TIME    = 32,
    parameter int WRITE_TIME   = 16,
    parameter int NBANKS       = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  read_avail,
    input  logic                  write_avail,
    input  logic                  cmd_valid,
    input  logic                  req_valid,
    input  logic                  act_fire,
    input  logic                  cas_fire,
    input  logic                  refresh_valid,
    input  logic [NBANKS-1:0]     refresh_gnt,
    output logic                  want_cmds,
    output logic                  want_acts,
    output logic                  want_reads,
    output logic                  want_writes,
    output logic [2*NPHASES-1:0]  steer_sel,
    output logic                  refresh_req,
    output logic                  refresh_ack,
    output logic [2:0]            mode
);
    localparam int  WR_LAT      = (CWL + NPHASES - 1) / NPHASES;
    localparam int  WTR_LATENCY = T_WTR + WR_LAT + T_CCD;
    localparam bit  RD_SHARED   = (RD_PH == RD_CMD_PH);
    localparam bit  WR_SHARED   = (WR_PH == WR_CMD_PH);

    sched_state_e state;
    logic         ref_fire;
    logic         act_ok;
    logic         cas_ok;

    sched_fsm #(
        .READ_LATENCY (READ_LATENCY),
        .WTR_LATENCY  (WTR_LATENCY),
        .READ_TIME    (READ_TIME),
        .WRITE_TIME   (WRITE_TIME)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .read_avail    (read_avail),
        .write_avail   (write_avail),
        .refresh_valid (refresh_valid),
        .all_granted   (&refresh_gnt),
        .state         (state),
        .ref_fire      (ref_fire)
    );

    spacing_timer #(.LIMIT(T_RRD)) u_rrd (
        .clk (clk), .rst_n (rst_n), .fire (act_fire), .ok (act_ok)
    );

    spacing_timer #(.LIMIT(T_CCD)) u_ccd (
        .clk (clk), .rst_n (rst_n), .fire (cas_fire), .ok (cas_ok)
    );

    phase_steer #(
        .NPHASES   (NPHASES),
        .RD_PH     (RD_PH),
        .RD_CMD_PH (RD_CMD_PH),
        .WR_PH     (WR_PH),
        .WR_CMD_PH (WR_CMD_PH)
    ) u_steer (
        .state     (state),
        .cmd_valid (cmd_valid),
        .req_valid (req_valid),
        .ref_fire  (ref_fire),
        .sel       (steer_sel)
    );

    logic in_rd, in_wr;
    assign in_rd = (state == ST_READ);
    assign in_wr = (state == ST_WRITE);

    assign want_cmds   = in_rd || in_wr;
    assign want_acts   = (in_rd || in_wr) && act_ok;
    assign want_reads  = in_rd && cas_ok && !(RD_SHARED && cmd_valid);
    assign want_writes = in_wr && cas_ok && !(WR_SHARED && cmd_valid);
    assign refresh_req = (state == ST_REFRESH);
    assign refresh_ack = ref_fire;
    assign mode        = state;

    assert_one_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(want_reads && want_writes));

    assert_refresh_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_ack |-> ((&refresh_gnt) && refresh_req && !want_cmds));

    generate
        for (genvar p = 1; p < NPHASES; p++) begin : g_ref_slot
            assert_ref_phase0_R11: assert property (@(posedge clk) disable iff (!rst_n)
                steer_sel[2*p +: 2] != SLOT_REF);
        end
    endgenerate

endmodule

// File: tb/sim_dram_turnaround_sched.sv
`timescale 1ns/1ps
module sim_dram_turnaround_sched;
    localparam int NB     = 4;
    localparam int RL     = 5;
    localparam int CWL    = 3;
    localparam int NPH    = 2;
    localparam int TWTR   = 2;
    localparam int TCCD   = 3;
    localparam int TRRD   = 6;
    localparam int RTIME  = 32;
    localparam int WTIME  = 16;
    localparam int WTRCYC = TWTR + (CWL + NPH - 1) / NPH + TCCD;

    logic clk = 0;
    logic rst_n = 0;
    logic read_avail = 0, write_avail = 0, cmd_valid = 0, req_valid = 0;
    logic act_fire = 0, cas_fire = 0, refresh_valid = 0;
    logic [NB-1:0] refresh_gnt = '0;

    logic want_cmds, want_acts, want_reads, want_writes, refresh_req, refresh_ack;
    logic [3:0] steer_sel;
    logic [2:0] mode;
    logic w1_cmds, w1_acts, w1_reads, w1_writes, r1_req, r1_ack;
    logic [1:0] sel1;
    logic [2:0] mode1;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    dram_turnaround_sched #(
        .NPHASES(NPH), .RD_PH(0), .RD_CMD_PH(1), .WR_PH(1), .WR_CMD_PH(0),
        .READ_LATENCY(RL), .CWL(CWL), .T_WTR(TWTR), .T_CCD(TCCD), .T_RRD(TRRD),
        .READ_TIME(RTIME), .WRITE_TIME(WTIME), .NBANKS(NB)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .read_avail(read_avail), .write_avail(write_avail),
        .cmd_valid(cmd_valid), .req_valid(req_valid), .act_fire(act_fire),
        .cas_fire(cas_fire), .refresh_valid(refresh_valid), .refresh_gnt(refresh_gnt),
        .want_cmds(want_cmds), .want_acts(want_acts), .want_reads(want_reads),
        .want_writes(want_writes), .steer_sel(steer_sel), .refresh_req(refresh_req),
        .refresh_ack(refresh_ack), .mode(mode)
    );

    dram_turnaround_sched #(
        .NPHASES(1), .RD_PH(0), .RD_CMD_PH(0), .WR_PH(0), .WR_CMD_PH(0),
        .READ_LATENCY(RL), .CWL(CWL), .T_WTR(TWTR), .T_CCD(TCCD), .T_RRD(TRRD),
        .READ_TIME(RTIME), .WRITE_TIME(WTIME), .NBANKS(NB)
    ) u1 (
        .clk(clk), .rst_n(rst_n), .read_avail(read_avail), .write_avail(write_avail),
        .cmd_valid(cmd_valid), .req_valid(req_valid), .act_fire(act_fire),
        .cas_fire(cas_fire), .refresh_valid(refresh_valid), .refresh_gnt(refresh_gnt),
        .want_cmds(w1_cmds), .want_acts(w1_acts), .want_reads(w1_reads),
        .want_writes(w1_writes), .steer_sel(sel1), .refresh_req(r1_req),
        .refresh_ack(r1_ack), .mode(mode1)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
    endtask

    task automatic wait_mode(input int m);
        for (int g = 0; g < 200 && mode != 3'(m); g++) tick();
    endtask

    initial begin
        #(200000 * 10);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int cnt;
        do_reset();

        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 want_cmds", want_cmds, 1);
        chk("R1 want_acts", want_acts, 1);
        chk("R1 want_reads", want_reads, 1);
        chk("R1 want_writes", want_writes, 0);
        chk("R1 refresh_req", refresh_req, 0);

        // R10 single-phase slot priority, R9 read-mode steering, swept over valids
        for (int v = 0; v < 4; v++) begin
            cmd_valid = v[0];
            req_valid = v[1];
            #1;
            chk("R10 sel", sel1, v[0] ? 1 : (v[1] ? 2 : 0));
            chk("R10 want_reads", w1_reads, v[0] ? 0 : 1);
            chk("R9 rd phase0", steer_sel[1:0], v[1] ? 2 : 0);
            chk("R9 rd phase1", steer_sel[3:2], v[0] ? 1 : 0);
        end
        cmd_valid = 0;
        req_valid = 0;

        // R5 read mode holds without pending write
        read_avail = 1;
        for (int k = 0; k < 8; k++) begin
            tick();
            chk("R5 stay read", mode, 0);
        end

        // R7 activate spacing
        act_fire = 1;
        tick();
        act_fire = 0;
        cnt = 0;
        while (!want_acts && cnt < 50) begin
            cnt++;
            tick();
        end
        chk("R7 act gap", cnt, TRRD - 1);

        // R8 column spacing
        cas_fire = 1;
        tick();
        cas_fire = 0;
        cnt = 0;
        while (!want_reads && cnt < 50) begin
            cnt++;
            tick();
        end
        chk("R8 cas gap", cnt, TCCD - 1);

        // R2 read-to-write turnaround
        read_avail = 0;
        write_avail = 1;
        for (int k = 0; k <= RL; k++) begin
            chk("R2 rtw seq", mode, (k == 0) ? 0 : ((k < RL) ? 1 : 2));
            if (k > 0 && k < RL) chk("R6 wait idle", want_cmds, 0);
            if (k < RL) tick();
        end

        // R6 write-mode enables, R9 write-mode steering
        chk("R6 want_writes", want_writes, 1);
        chk("R6 want_reads", want_reads, 0);
        chk("R6 want_cmds", want_cmds, 1);
        cmd_valid = 1;
        req_valid = 1;
        #1;
        chk("R9 wr phase1", steer_sel[3:2], 2);
        chk("R9 wr phase0", steer_sel[1:0], 1);
        cmd_valid = 0;
        req_valid = 0;
        tick();
        chk("R5 stay write", mode, 2);

        // R3 write-to-read turnaround
        write_avail = 0;
        read_avail = 1;
        for (int k = 0; k <= WTRCYC; k++) begin
            chk("R3 wtr seq", mode, (k == 0) ? 2 : ((k < WTRCYC) ? 3 : 0));
            if (k < WTRCYC) tick();
        end

        // R4 anti-starvation windows with both directions pending
        write_avail = 1;
        cnt = 0;
        while (mode == 3'd0 && cnt < 500) begin
            cnt++;
            tick();
        end
        chk("R4 read window", cnt, RTIME);
        wait_mode(2);
        cnt = 0;
        while (mode == 3'd2 && cnt < 500) begin
            cnt++;
            tick();
        end
        chk("R4 write window", cnt, WTIME);
        chk("R4 leaves to wtr", mode, 3);

        // R11 refresh from read mode
        write_avail = 0;
        read_avail = 0;
        wait_mode(0);
        refresh_valid = 1;
        tick();
        chk("R11 mode", mode, 4);
        chk("R11 refresh_req", refresh_req, 1);
        chk("R11 no cmds", want_cmds, 0);
        for (int b = 0; b < NB; b++) begin
            refresh_gnt[b] = 1'b1;
            #1;
            chk("R11 ack", refresh_ack, (b == NB - 1) ? 1 : 0);
            chk("R11 phase0", steer_sel[1:0], (b == NB - 1) ? 3 : 0);
            if (b < NB - 1) begin
                tick();
                chk("R11 held", mode, 4);
            end
        end
        tick();
        refresh_valid = 0;
        refresh_gnt = '0;
        chk("R11 back to read", mode, 0);
        chk("R11 req drop", refresh_req, 0);

        // R12 refresh from write mode passes the turnaround
        write_avail = 1;
        wait_mode(2);
        write_avail = 0;
        refresh_valid = 1;
        tick();
        chk("R12 to wtr", mode, 3);
        cnt = 1;
        while (mode == 3'd3 && cnt < 100) begin
            cnt++;
            tick();
        end
        chk("R12 wtr length", cnt, WTRCYC);
        chk("R12 via read", mode, 0);
        tick();
        chk("R12 refresh", mode, 4);
        refresh_gnt = '1;
        #1;
        chk("R12 ack", refresh_ack, 1);
        tick();
        refresh_valid = 0;
        refresh_gnt = '0;

        // R4 read counter expired after reset
        read_avail = 1;
        write_avail = 1;
        do_reset();
        chk("R4 expired after reset", mode, 1);
        read_avail = 0;
        write_avail = 0;

        finish_run();
    end
endmodule